// File: doc/BRIEF.md
# Error-Tagged Receive Character Queue

This block is the receive-side character store of a serial port channel. A receiver hands it one character per accepted frame, together with three per-character error tags: parity error, framing error and break. The host bus side pops characters in arrival order. Each character keeps its own tags, so the head entry always shows the tags of the character being read.

Besides the usual occupancy and data-ready outputs, the block raises an aggregate error flag. The flag is high while any stored character, not only the head, carries at least one error tag. It is derived from a running count of errored entries. The block also forms a transmitter-idle flag from two status inputs that report whether the transmit queue and the transmit shift register are empty.

Top module: `uart_rxq_top`

## Requirements
- R1: After reset, occupancy is 0, data_ready is 0, err_any is 0 and overrun is 0. The head outputs (head_char, head_perr, head_ferr, head_brk) are all 0.
- R2: An accepted push stores the character with its three tags. Entries leave in first-in first-out order. The head outputs show the oldest stored entry. data_ready is 1 exactly when occupancy is non-zero.
- R3: occupancy rises by one after an accepted push and falls by one after an accepted pop. A push and a pop accepted in the same cycle leave occupancy unchanged.
- R4: The queue holds 128 entries. A push while occupancy is 128 and no pop is accepted in the same cycle is dropped and leaves the contents unchanged. overrun is then 1 for exactly the following cycle. A push while full, made together with a pop, is accepted.
- R5: A pop while the queue is empty has no effect on occupancy or on the error state. While empty, all head outputs read 0.
- R6: An entry counts as errored when any of its three tags is 1. err_any is 1 from the cycle after the first errored entry is stored. It returns to 0 in the cycle after the last errored entry is popped.
- R7: err_any stays 1 while the head entry is clean but an errored entry sits further back in the queue.
- R8: A cycle with flush high clears occupancy, the stored error count and overrun by the next cycle. A push or pop made in that cycle is ignored.
- R9: tx_idle is 1 exactly when both tx_q_empty and tx_sr_empty are 1, in the same cycle and with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous queue clear |
| wr_en | input | 1 | Push request from the receiver |
| wr_char | input | 8 | Character to push |
| wr_perr | input | 1 | Parity error tag of the pushed character |
| wr_ferr | input | 1 | Framing error tag of the pushed character |
| wr_brk | input | 1 | Break tag of the pushed character |
| rd_en | input | 1 | Pop request from the host side |
| tx_q_empty | input | 1 | Transmit queue or holding storage is empty |
| tx_sr_empty | input | 1 | Transmit shift register is empty |
| data_ready | output | 1 | Queue holds at least one entry |
| occupancy | output | 8 | Number of stored entries (0 to 128) |
| head_char | output | 8 | Character at the head, 0 when empty |
| head_perr | output | 1 | Parity tag of the head entry |
| head_ferr | output | 1 | Framing tag of the head entry |
| head_brk | output | 1 | Break tag of the head entry |
| err_any | output | 1 | At least one stored entry is errored |
| overrun | output | 1 | One-cycle pulse after a dropped push |
| tx_idle | output | 1 | Transmit path is fully empty |

## Verification
Occupancy, data_ready, the head outputs, err_any and overrun are all due one clock edge after the push, pop or flush that changes them. tx_idle is due in the same cycle as its inputs. The bench drives each cycle's inputs on the falling edge and advances a queue-based model at the rising edge. It compares every output at the next falling edge, so registered results are sampled one edge after the stimulus. The same compare also checks tx_idle against the inputs that are currently applied.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
    localparam int CHAR_W = 8;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [CHAR_W-1:0] ch;
    } rxq_entry_t;

    function automatic logic entry_errored(rxq_entry_t e);
        return e.brk | e.ferr | e.perr;
    endfunction
endpackage

// File: rtl/uart_rxq_ctrl.sv
module uart_rxq_ctrl #(
    parameter int DEPTH = 128,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic             push,
    output logic             pop,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] occ,
    output logic             overrun
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] occ;
        logic             ovr;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  empty, full;

    always_comb begin
        empty = (st_q.occ == '0);
        full  = (st_q.occ == FULL_CNT);
        pop   = rd_en & ~empty & ~flush;
        push  = wr_en & (~full | pop) & ~flush;
        st_d  = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (push) st_d.wp = (st_q.wp == LAST_PTR) ? '0 : st_q.wp + 1'b1;
            if (pop)  st_d.rp = (st_q.rp == LAST_PTR) ? '0 : st_q.rp + 1'b1;
            st_d.occ = st_q.occ + CNT_W'(push) - CNT_W'(pop);
            st_d.ovr = wr_en & full & ~pop;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_ptr  = st_q.wp;
    assign rd_ptr  = st_q.rp;
    assign occ     = st_q.occ;
    assign overrun = st_q.ovr;

    // R4
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.occ <= FULL_CNT);

    // R4
    ovr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en && !flush) |=> (overrun && occ == FULL_CNT));

    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occ == '0 && !overrun));

    // R5
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !wr_en && !flush) |=> (occ == '0));
endmodule

// File: rtl/uart_rxq_store.sv
module uart_rxq_store
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  rxq_entry_t       wdata,
    input  logic [PTR_W-1:0] raddr,
    output rxq_entry_t       rdata
);
    rxq_entry_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/uart_rxq_errtrack.sv
module uart_rxq_errtrack #(
    parameter int DEPTH = 128,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             push_err,
    input  logic             pop,
    input  logic             pop_err,
    input  logic [CNT_W-1:0] occ,
    output logic             err_any
);
    logic [CNT_W-1:0] ecnt_d, ecnt_q;

    always_comb begin
        if (flush) ecnt_d = '0;
        else       ecnt_d = ecnt_q + CNT_W'(push & push_err) - CNT_W'(pop & pop_err);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ecnt_q <= '0;
        else        ecnt_q <= ecnt_d;
    end

    assign err_any = (ecnt_q != '0);

    // R6
    err_le_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ecnt_q <= occ);

    // R8
    err_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !err_any);

    // R6
    err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_err && !pop) |=> err_any);
endmodule

// File: rtl/uart_rxq_top.sv
module uart_rxq_top
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_char,
    input  logic              wr_perr,
    input  logic              wr_ferr,
    input  logic              wr_brk,
    input  logic              rd_en,
    input  logic              tx_q_empty,
    input  logic              tx_sr_empty,
    output logic              data_ready,
    output logic [CNT_W-1:0]  occupancy,
    output logic [CHAR_W-1:0] head_char,
    output logic              head_perr,
    output logic              head_ferr,
    output logic              head_brk,
    output logic              err_any,
    output logic              overrun,
    output logic              tx_idle
);
    logic             push, pop;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    rxq_entry_t       wr_ent, rd_ent, head_ent;

    assign wr_ent = '{brk: wr_brk, ferr: wr_ferr, perr: wr_perr, ch: wr_char};

    uart_rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .rd_en(rd_en),
        .push(push), .pop(pop), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .occ(occupancy), .overrun(overrun)
    );

    uart_rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .we(push), .waddr(wr_ptr), .wdata(wr_ent),
        .raddr(rd_ptr), .rdata(rd_ent)
    );

    uart_rxq_errtrack #(.DEPTH(DEPTH)) u_err (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(push), .push_err(entry_errored(wr_ent)),
        .pop(pop), .pop_err(entry_errored(rd_ent)),
        .occ(occupancy), .err_any(err_any)
    );

    assign data_ready = (occupancy != '0);
    assign head_ent   = data_ready ? rd_ent : '0;
    assign head_char  = head_ent.ch;
    assign head_perr  = head_ent.perr;
    assign head_ferr  = head_ent.ferr;
    assign head_brk   = head_ent.brk;
    assign tx_idle    = tx_q_empty & tx_sr_empty;

    // R2
    ready_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush) |=> data_ready);
endmodule

// File: tb/uart_rxq_top_test.sv
module uart_rxq_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 128;
    localparam int WATCHDOG   = 20000;

    logic clk = 0, rst_n = 0, flush = 0, wr_en = 0, rd_en = 0;
    logic [7:0] wr_char = 0;
    logic wr_perr = 0, wr_ferr = 0, wr_brk = 0;
    logic tx_q_empty = 0, tx_sr_empty = 0;
    logic data_ready, head_perr, head_ferr, head_brk, err_any, overrun, tx_idle;
    logic [7:0] occupancy, head_char;

    uart_rxq_top #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_char(wr_char),
        .wr_perr(wr_perr), .wr_ferr(wr_ferr), .wr_brk(wr_brk), .rd_en(rd_en),
        .tx_q_empty(tx_q_empty), .tx_sr_empty(tx_sr_empty),
        .data_ready(data_ready), .occupancy(occupancy), .head_char(head_char),
        .head_perr(head_perr), .head_ferr(head_ferr), .head_brk(head_brk),
        .err_any(err_any), .overrun(overrun), .tx_idle(tx_idle)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int errors = 0, checks = 0, cycles = 0;
    logic [10:0] model_q [$];
    logic exp_ovr = 0;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        logic [10:0] h;
        int nerr = 0;
        h = (model_q.size() > 0) ? model_q[0] : 11'd0;
        foreach (model_q[i]) if (model_q[i][10:8] != 0) nerr++;
        chk(tag, "occupancy", occupancy, model_q.size());
        chk(tag, "data_ready", data_ready, model_q.size() > 0);
        chk(tag, "head_char", head_char, h[7:0]);
        chk(tag, "head_perr", head_perr, h[8]);
        chk(tag, "head_ferr", head_ferr, h[9]);
        chk(tag, "head_brk", head_brk, h[10]);
        chk(tag, "err_any", err_any, nerr > 0);
        chk(tag, "overrun", overrun, exp_ovr);
        chk(tag, "tx_idle", tx_idle, tx_q_empty & tx_sr_empty);
    endtask

    task automatic step(string tag, logic we, logic [7:0] ch, logic [2:0] tags,
                        logic re, logic fl);
        bit full, pop_ok, push_ok;
        wr_en = we; wr_char = ch; {wr_brk, wr_ferr, wr_perr} = tags;
        rd_en = re; flush = fl;
        full    = (model_q.size() == DEPTH);
        pop_ok  = re && model_q.size() > 0 && !fl;
        push_ok = we && (!full || pop_ok) && !fl;
        @(posedge clk);
        exp_ovr = we && full && !pop_ok && !fl;
        if (fl) model_q.delete();
        else begin
            if (pop_ok)  void'(model_q.pop_front());
            if (push_ok) model_q.push_back({tags, ch});
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(string tag);
        step(tag, 0, 8'h00, 3'b000, 0, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                errors++; checks++;
                $display("FAIL watchdog expired");
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        compare("R1");

        // R2: ordered pushes of clean characters
        for (int i = 0; i < 5; i++) step("R2", 1, 8'h41 + 8'(i), 3'b000, 0, 0);
        idle("R2");

        // R3: pops, then simultaneous push and pop
        for (int i = 0; i < 2; i++) step("R3", 0, 8'h00, 3'b000, 1, 0);
        for (int i = 0; i < 3; i++) step("R3", 1, 8'h60 + 8'(i), 3'b000, 1, 0);
        while (model_q.size() > 0) step("R3", 0, 8'h00, 3'b000, 1, 0);

        // R6: each tag marks an entry errored; flag drops after the last one leaves
        step("R6", 1, 8'h11, 3'b010, 0, 0);
        step("R6", 1, 8'h12, 3'b000, 0, 0);
        step("R6", 1, 8'h13, 3'b100, 0, 0);
        step("R6", 1, 8'h14, 3'b001, 0, 0);
        for (int i = 0; i < 5; i++) step("R6", 0, 8'h00, 3'b000, 1, 0);

        // R7: errored entry behind clean heads
        for (int i = 0; i < 3; i++) step("R7", 1, 8'h20 + 8'(i), 3'b000, 0, 0);
        step("R7", 1, 8'h2A, 3'b001, 0, 0);
        step("R7", 1, 8'h2B, 3'b000, 0, 0);
        for (int i = 0; i < 5; i++) step("R7", 0, 8'h00, 3'b000, 1, 0);

        // R4: fill to depth, overflow, push with pop while full
        for (int i = 0; i < DEPTH; i++)
            step("R4", 1, 8'($urandom_range(0, 255)),
                 ($urandom_range(0, 7) == 0) ? 3'($urandom_range(1, 7)) : 3'b000, 0, 0);
        for (int i = 0; i < 3; i++) step("R4", 1, 8'hEE, 3'b111, 0, 0);
        idle("R4");
        step("R4", 1, 8'hD5, 3'b010, 1, 0);
        while (model_q.size() > 0) step("R3", 0, 8'h00, 3'b000, 1, 0);

        // R5: pops while empty, and pop with push on empty
        for (int i = 0; i < 3; i++) step("R5", 0, 8'h00, 3'b000, 1, 0);
        step("R5", 1, 8'h77, 3'b100, 1, 0);
        step("R5", 0, 8'h00, 3'b000, 1, 0);
        step("R5", 0, 8'h00, 3'b000, 1, 0);

        // R8: flush overrides push and pop, clears error state and overrun
        for (int i = 0; i < 10; i++) step("R8", 1, 8'h30 + 8'(i), 3'(i % 3), 0, 0);
        step("R8", 1, 8'h99, 3'b111, 1, 1);
        idle("R8");
        for (int i = 0; i < DEPTH; i++) step("R8", 1, 8'(i), 3'b001, 0, 0);
        step("R8", 1, 8'hFF, 3'b000, 0, 0);
        step("R8", 0, 8'h00, 3'b000, 0, 1);
        idle("R8");

        // R9: every combination of the transmit status inputs
        for (int i = 0; i < 4; i++) begin
            tx_q_empty = i[0]; tx_sr_empty = i[1];
            #1;
            chk("R9", "tx_idle", tx_idle, i == 3);
            idle("R9");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule